// File: doc/BRIEF.md
# Ethernet MAC Control and Interrupt Register Block

This block is the software-visible control register file of a simple Ethernet MAC. A 32-bit register port reads and writes a 4 KiB window. The window holds four things. The first is an interrupt cause register that the transmit and receive engines set, and that software clears by AND-writing. The second is a mask register that gates the cause bits onto one level interrupt line. The third is a management window whose PHY reads are answered by a built-in stub PHY. The fourth is a set of descriptor queue pointers for the DMA engines.

A write to the DMA command register starts transmit queues. The block turns the command into one start pulse per queue, issued one cycle apart, with the high queue first. A write to a current-receive pointer also hands that pointer to the receive engine as its new working pointer. A port configuration bit selects a 2-byte receive data offset, and the block exports that offset to the receive engine. Read data is registered and appears on the cycle after the read strobe.

Top module: `emac_ctrl_regs`

## Requirements
- R1: After reset every register reads 0, `irq` is low, `rx_offset` is 0, and no start or load pulse is active.
- R2: A write to the cause register (offset 0x450) replaces the cause with (cause AND written value). A read leaves the cause unchanged. Cause bits never rise without an event.
- R3: `ev_rx_done` sets cause bit 0. `ev_tx_done[0]` (low queue) sets bit 3 and `ev_tx_done[1]` (high queue) sets bit 2. When an event and an AND-write fall in the same cycle, the event's bit ends up set.
- R4: `irq` is high exactly when (cause AND mask) was nonzero on the previous cycle.
- R5: The mask register (offset 0x458) stores and reads back all 32 bits.
- R6: When bit 26 (read opcode) of the stored management word (offset 0x010) is set, a read returns bit 27 (read-valid) set, with bits 15:0 chosen by bits 25:16: 0x021 gives 0x000C, 0x041 gives 0x0141, 0x061 gives 0x0E20, and any other value gives 0. The written data bits do not appear in the result.
- R7: When bit 26 of the stored management word is clear, a read of the management offset returns 0.
- R8: Bit 28 of the port configuration register (offset 0x408) sets `rx_offset` to 2. When that bit is clear, `rx_offset` is 0. A read returns only bit 28.
- R9: A write to the DMA command register (offset 0x448) with bit 23 set starts queue 1, and bit 22 set starts queue 0. A start shows as a one-cycle `tx_go` pulse with `tx_go_q` set to the queue, beginning the cycle after the write. When both bits are set, queue 1 pulses first and queue 0 pulses on the next cycle. The command register reads 0.
- R10: The first-receive pointers 0..3 (0x480 to 0x48C), the current-receive pointers 0..3 (0x4A0 to 0x4AC) and the current-transmit pointers 0..1 (0x4E0 to 0x4E4) each store and read back 32 bits, at a stride of 4.
- R11: A write to current-receive pointer n gives a one-cycle `rx_ld_valid` pulse on the next cycle, with `rx_ld_q` = n and `rx_ld_ptr` = the written value.
- R12: Reads of unmapped or unaligned offsets return 0. Writes to them change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` |
| ev_rx_done | input | 1 | Receive engine completed a frame |
| ev_tx_done | input | 2 | Transmit engine completed a descriptor, one bit per queue |
| irq | output | 1 | Level interrupt |
| rx_offset | output | 2 | Receive data offset in bytes (0 or 2) |
| tx_go | output | 1 | Transmit queue start pulse |
| tx_go_q | output | 1 | Queue index for `tx_go` |
| rx_ld_valid | output | 1 | Receive working-pointer load pulse |
| rx_ld_q | output | 2 | Receive queue for the load |
| rx_ld_ptr | output | 32 | Pointer value to load |

## Verification
The bound checker watches several rules on every cycle. A cause bit never rises without an event, and a receive event always leaves bit 0 set. The interrupt stays low while the mask is zero. An idle management word reads 0, and an unmapped offset reads 0. A high-queue command starts queue 1 first. A current-receive write always produces the matching load pulse, and the receive offset is only ever 0 or 2. The directed scenarios cover the behaviour that needs specific data. They check the AND-clear arithmetic and the stub PHY's per-address answers. They check the one-cycle interrupt latency in both directions, the second start pulse of a dual command, and the read-back of every pointer. They also confirm that writes to unmapped and unaligned offsets disturb nothing.

// File: rtl/emac_regs_pkg.sv
package emac_regs_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_MGMT    = 12'h010;
  localparam logic [REG_AW-1:0] OFS_PORT    = 12'h408;
  localparam logic [REG_AW-1:0] OFS_DMA     = 12'h448;
  localparam logic [REG_AW-1:0] OFS_CAUSE   = 12'h450;
  localparam logic [REG_AW-1:0] OFS_MASK    = 12'h458;
  localparam logic [REG_AW-1:0] OFS_RXFIRST = 12'h480;
  localparam logic [REG_AW-1:0] OFS_RXCUR   = 12'h4A0;
  localparam logic [REG_AW-1:0] OFS_TXCUR   = 12'h4E0;

  // management word layout
  localparam int MGMT_SEL_LSB = 16;
  localparam int MGMT_SEL_W   = 10;
  localparam int MGMT_RD_BIT  = 26;
  localparam int MGMT_OK_BIT  = 27;

  localparam logic [MGMT_SEL_W-1:0] SEL_STATUS = 10'h021;
  localparam logic [MGMT_SEL_W-1:0] SEL_ID_HI  = 10'h041;
  localparam logic [MGMT_SEL_W-1:0] SEL_ID_LO  = 10'h061;
  localparam logic [15:0] STUB_STATUS = 16'h000C;
  localparam logic [15:0] STUB_ID_HI  = 16'h0141;
  localparam logic [15:0] STUB_ID_LO  = 16'h0E20;

  localparam int PORT_OFS_BIT = 28;
  localparam int DMA_TX_LSB   = 22;
  localparam int CAUSE_RX_BIT = 0;
  localparam int CAUSE_TX_TOP = 3;
endpackage

// File: rtl/emac_phy_stub.sv
module emac_phy_stub
  import emac_regs_pkg::*;
#(
  parameter int DW = REG_DW
) (
  input  logic [DW-1:0] cmd,
  output logic [DW-1:0] resp
);
  logic [MGMT_SEL_W-1:0] sel;
  logic [15:0]           data;

  assign sel = cmd[MGMT_SEL_LSB +: MGMT_SEL_W];

  always_comb begin
    unique case (sel)
      SEL_STATUS: data = STUB_STATUS;
      SEL_ID_HI:  data = STUB_ID_HI;
      SEL_ID_LO:  data = STUB_ID_LO;
      default:    data = 16'h0000;
    endcase
  end

  always_comb begin
    resp = '0;
    if (cmd[MGMT_RD_BIT]) begin
      resp[15:0]        = data;
      resp[MGMT_OK_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/emac_irq_ctrl.sv
module emac_irq_ctrl
  import emac_regs_pkg::*;
#(
  parameter int DW   = REG_DW,
  parameter int N_TX = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cause_wr,
  input  logic            mask_wr,
  input  logic [DW-1:0]   wdata,
  input  logic            ev_rx,
  input  logic [N_TX-1:0] ev_tx,
  output logic [DW-1:0]   cause_q,
  output logic [DW-1:0]   mask_q,
  output logic            irq
);
  logic [DW-1:0] set_vec;
  logic [DW-1:0] kept;

  always_comb begin
    set_vec = '0;
    set_vec[CAUSE_RX_BIT] = ev_rx;
    for (int q = 0; q < N_TX; q++) begin
      set_vec[CAUSE_TX_TOP - q] = set_vec[CAUSE_TX_TOP - q] | ev_tx[q];
    end
  end

  assign kept = cause_wr ? (cause_q & wdata) : cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq     <= 1'b0;
    end else begin
      cause_q <= kept | set_vec;
      if (mask_wr) mask_q <= wdata;
      irq     <= |(cause_q & mask_q);
    end
  end
endmodule

// File: rtl/emac_tx_kick.sv
module emac_tx_kick #(
  parameter int N_TX = 2,
  parameter int QW   = (N_TX > 1) ? $clog2(N_TX) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic [N_TX-1:0] req,
  output logic            go,
  output logic [QW-1:0]   go_q
);
  logic [N_TX-1:0] pending_q;
  logic [N_TX-1:0] merged;
  logic [N_TX-1:0] pick_mask;
  logic [QW-1:0]   pick;
  logic            found;

  assign merged = pending_q | (cmd_wr ? req : '0);

  // highest index wins: later iterations overwrite earlier ones
  always_comb begin
    found     = 1'b0;
    pick      = '0;
    pick_mask = '0;
    for (int q = 0; q < N_TX; q++) begin
      if (merged[q]) begin
        found     = 1'b1;
        pick      = QW'(q);
        pick_mask = N_TX'(1) << q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      go        <= 1'b0;
      go_q      <= '0;
    end else begin
      go        <= found;
      go_q      <= pick;
      pending_q <= merged & ~pick_mask;
    end
  end
endmodule

// File: rtl/emac_ptr_bank.sv
module emac_ptr_bank #(
  parameter int NQ = 4,
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int IW = (NQ > 1) ? $clog2(NQ) : 1,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [DW-1:0] rd_val
);
  localparam logic [AW-1:0] SPAN = AW'(4 * NQ);

  logic [AW-1:0] rel;
  logic [DW-1:0] ptr_q [NQ];

  assign rel = addr - BASE;
  assign hit = (addr >= BASE) && (rel < SPAN) && (rel[1:0] == 2'b00);
  assign idx = rel[IW+1:2];

  for (genvar g = 0; g < NQ; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) ptr_q[g] <= '0;
      else if (wr_en && hit && (idx == IW'(g))) ptr_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int q = 0; q < NQ; q++) begin
      if (idx == IW'(q)) rd_val = ptr_q[q];
    end
  end
endmodule

// File: rtl/emac_ctrl_regs.sv
module emac_ctrl_regs
  import emac_regs_pkg::*;
#(
  parameter int DW   = REG_DW,
  parameter int AW   = REG_AW,
  parameter int N_RX = 4,
  parameter int N_TX = 2,
  parameter int RQW  = (N_RX > 1) ? $clog2(N_RX) : 1,
  parameter int TQW  = (N_TX > 1) ? $clog2(N_TX) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ev_rx_done,
  input  logic [N_TX-1:0] ev_tx_done,
  output logic            irq,
  output logic [1:0]      rx_offset,
  output logic            tx_go,
  output logic [TQW-1:0]  tx_go_q,
  output logic            rx_ld_valid,
  output logic [RQW-1:0]  rx_ld_q,
  output logic [DW-1:0]   rx_ld_ptr
);
  logic [DW-1:0] mgmt_q;
  logic [DW-1:0] mgmt_resp;
  logic          port_ofs_q;
  logic [DW-1:0] cause_q;
  logic [DW-1:0] mask_q;

  logic hit_mgmt, hit_port, hit_dma, hit_cause, hit_mask;
  assign hit_mgmt  = (reg_addr == OFS_MGMT);
  assign hit_port  = (reg_addr == OFS_PORT);
  assign hit_dma   = (reg_addr == OFS_DMA);
  assign hit_cause = (reg_addr == OFS_CAUSE);
  assign hit_mask  = (reg_addr == OFS_MASK);

  logic          hit_rxf, hit_rxc, hit_txc;
  logic [RQW-1:0] idx_rxf, idx_rxc;
  logic [TQW-1:0] idx_txc;
  logic [DW-1:0] val_rxf, val_rxc, val_txc;

  emac_ptr_bank #(.NQ(N_RX), .DW(DW), .AW(AW), .IW(RQW), .BASE(OFS_RXFIRST)) u_rxfirst (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit_rxf), .idx(idx_rxf), .rd_val(val_rxf));

  emac_ptr_bank #(.NQ(N_RX), .DW(DW), .AW(AW), .IW(RQW), .BASE(OFS_RXCUR)) u_rxcur (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit_rxc), .idx(idx_rxc), .rd_val(val_rxc));

  emac_ptr_bank #(.NQ(N_TX), .DW(DW), .AW(AW), .IW(TQW), .BASE(OFS_TXCUR)) u_txcur (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit_txc), .idx(idx_txc), .rd_val(val_txc));

  emac_irq_ctrl #(.DW(DW), .N_TX(N_TX)) u_irq (
    .clk(clk), .rst(rst),
    .cause_wr(reg_wr && hit_cause), .mask_wr(reg_wr && hit_mask),
    .wdata(reg_wdata), .ev_rx(ev_rx_done), .ev_tx(ev_tx_done),
    .cause_q(cause_q), .mask_q(mask_q), .irq(irq));

  emac_tx_kick #(.N_TX(N_TX), .QW(TQW)) u_kick (
    .clk(clk), .rst(rst), .cmd_wr(reg_wr && hit_dma),
    .req(reg_wdata[DMA_TX_LSB +: N_TX]), .go(tx_go), .go_q(tx_go_q));

  emac_phy_stub #(.DW(DW)) u_phy (.cmd(mgmt_q), .resp(mgmt_resp));

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt_q     <= '0;
      port_ofs_q <= 1'b0;
    end else if (reg_wr) begin
      if (hit_mgmt) mgmt_q     <= reg_wdata;
      if (hit_port) port_ofs_q <= reg_wdata[PORT_OFS_BIT];
    end
  end

  assign rx_offset = {port_ofs_q, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ld_valid <= 1'b0;
      rx_ld_q     <= '0;
      rx_ld_ptr   <= '0;
    end else begin
      rx_ld_valid <= reg_wr && hit_rxc;
      if (reg_wr && hit_rxc) begin
        rx_ld_q   <= idx_rxc;
        rx_ld_ptr <= reg_wdata;
      end
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_mgmt)       rd_mux = mgmt_resp;
    else if (hit_port)  rd_mux[PORT_OFS_BIT] = port_ofs_q;
    else if (hit_cause) rd_mux = cause_q;
    else if (hit_mask)  rd_mux = mask_q;
    else if (hit_rxf)   rd_mux = val_rxf;
    else if (hit_rxc)   rd_mux = val_rxc;
    else if (hit_txc)   rd_mux = val_txc;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/emac_ctrl_regs_chk.sv
module emac_ctrl_regs_chk
  import emac_regs_pkg::*;
#(
  parameter int DW   = REG_DW,
  parameter int AW   = REG_AW,
  parameter int N_RX = 4,
  parameter int N_TX = 2,
  parameter int TQW  = 1
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic            ev_rx_done,
  input logic [N_TX-1:0] ev_tx_done,
  input logic            irq,
  input logic [1:0]      rx_offset,
  input logic            tx_go,
  input logic [TQW-1:0]  tx_go_q,
  input logic            rx_ld_valid,
  input logic [DW-1:0]   rx_ld_ptr,
  input logic [DW-1:0]   cause_q,
  input logic [DW-1:0]   mask_q,
  input logic [DW-1:0]   mgmt_q
);
  localparam logic [AW-1:0] RXC_END = OFS_RXCUR + AW'(4 * N_RX);

  logic rxc_wr;
  assign rxc_wr = reg_wr && (reg_addr >= OFS_RXCUR) && (reg_addr < RXC_END)
                  && (reg_addr[1:0] == 2'b00);

  AST_RX_EVENT_SETS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ev_rx_done |=> cause_q[CAUSE_RX_BIT]); // R3

  AST_CAUSE_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!ev_rx_done && (ev_tx_done == '0)) |=> ((cause_q & ~$past(cause_q)) == '0)); // R2

  AST_IRQ_LOW_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq); // R4

  AST_MGMT_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == OFS_MGMT) && !mgmt_q[MGMT_RD_BIT]) |=> (reg_rdata == '0)); // R7

  AST_TX_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == OFS_DMA) && reg_wdata[DMA_TX_LSB + N_TX - 1])
    |=> (tx_go && (tx_go_q == TQW'(N_TX - 1)))); // R9

  AST_RXCUR_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rxc_wr |=> (rx_ld_valid && (rx_ld_ptr == $past(reg_wdata)))); // R11

  AST_RX_OFFSET_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (rx_offset == 2'd0) || (rx_offset == 2'd2)); // R8

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == 12'h454)) |=> (reg_rdata == '0)); // R12
endmodule

bind emac_ctrl_regs emac_ctrl_regs_chk #(
  .DW(DW), .AW(AW), .N_RX(N_RX), .N_TX(N_TX), .TQW(TQW)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rx_done(ev_rx_done),
  .ev_tx_done(ev_tx_done), .irq(irq), .rx_offset(rx_offset), .tx_go(tx_go),
  .tx_go_q(tx_go_q), .rx_ld_valid(rx_ld_valid), .rx_ld_ptr(rx_ld_ptr),
  .cause_q(cause_q), .mask_q(mask_q), .mgmt_q(mgmt_q)
);

// File: tb/emac_ctrl_regs_bench.sv
module emac_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_rx_done = 1'b0;
  logic [1:0]  ev_tx_done = '0;
  logic        irq;
  logic [1:0]  rx_offset;
  logic        tx_go;
  logic [0:0]  tx_go_q;
  logic        rx_ld_valid;
  logic [1:0]  rx_ld_q;
  logic [31:0] rx_ld_ptr;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  emac_ctrl_regs u_emac_ctrl_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rx_done(ev_rx_done),
    .ev_tx_done(ev_tx_done), .irq(irq), .rx_offset(rx_offset), .tx_go(tx_go),
    .tx_go_q(tx_go_q), .rx_ld_valid(rx_ld_valid), .rx_ld_q(rx_ld_q),
    .rx_ld_ptr(rx_ld_ptr));

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, $sformatf("read %h", a), v, exp);
  endtask

  task automatic pulse_ev(input logic rx, input logic [1:0] tx);
    @(negedge clk);
    ev_rx_done = rx; ev_tx_done = tx;
    @(negedge clk);
    ev_rx_done = 1'b0; ev_tx_done = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1", 12'h450, 32'h0);
    rd_chk("R1", 12'h458, 32'h0);
    rd_chk("R1", 12'h010, 32'h0);
    rd_chk("R1", 12'h4A0, 32'h0);
    rd_chk("R1", 12'h4E4, 32'h0);
    chk("R1", "irq", {31'b0, irq}, 32'h0);
    chk("R1", "rx_offset", {30'b0, rx_offset}, 32'h0);
    chk("R1", "tx_go", {31'b0, tx_go}, 32'h0);
    chk("R1", "rx_ld_valid", {31'b0, rx_ld_valid}, 32'h0);
  endtask

  task automatic t_events_and_clear;
    pulse_ev(1'b1, 2'b00);
    rd_chk("R3", 12'h450, 32'h1);
    pulse_ev(1'b0, 2'b01);
    rd_chk("R3", 12'h450, 32'h9);
    pulse_ev(1'b0, 2'b10);
    rd_chk("R3", 12'h450, 32'hD);
    rd_chk("R2", 12'h450, 32'hD);
    wr(12'h450, 32'hFFFF_FFF7);
    rd_chk("R2", 12'h450, 32'h5);
    wr(12'h450, 32'hFFFF_FFFE);
    rd_chk("R2", 12'h450, 32'h4);
    wr(12'h450, 32'h0);
    rd_chk("R2", 12'h450, 32'h0);
    // same-cycle event and clear: event wins
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h450; reg_wdata = 32'h0; ev_rx_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_rx_done = 1'b0;
    rd_chk("R3", 12'h450, 32'h1);
    wr(12'h450, 32'h0);
  endtask

  task automatic t_mask_irq;
    wr(12'h458, 32'hA5C3_0001);
    rd_chk("R5", 12'h458, 32'hA5C3_0001);
    wr(12'h458, 32'h0000_0001);
    @(negedge clk);
    chk("R4", "irq idle", {31'b0, irq}, 32'h0);
    pulse_ev(1'b1, 2'b00);
    chk("R4", "irq latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R4", "irq raised", {31'b0, irq}, 32'h1);
    wr(12'h458, 32'h0000_0004);
    @(negedge clk);
    chk("R4", "irq masked", {31'b0, irq}, 32'h0);
    wr(12'h458, 32'h0000_0001);
    @(negedge clk);
    chk("R4", "irq unmasked", {31'b0, irq}, 32'h1);
    wr(12'h450, 32'h0);
    @(negedge clk);
    chk("R4", "irq after clear", {31'b0, irq}, 32'h0);
    wr(12'h458, 32'h0);
  endtask

  task automatic t_mgmt;
    wr(12'h010, 32'h0421_ABCD);
    rd_chk("R6", 12'h010, 32'h0800_000C);
    wr(12'h010, 32'h0441_0000);
    rd_chk("R6", 12'h010, 32'h0800_0141);
    wr(12'h010, 32'h0461_0000);
    rd_chk("R6", 12'h010, 32'h0800_0E20);
    wr(12'h010, 32'h0481_0000);
    rd_chk("R6", 12'h010, 32'h0800_0000);
    wr(12'h010, 32'h0021_FFFF);
    rd_chk("R7", 12'h010, 32'h0);
  endtask

  task automatic t_port;
    wr(12'h408, 32'h1000_0000);
    chk("R8", "rx_offset set", {30'b0, rx_offset}, 32'h2);
    rd_chk("R8", 12'h408, 32'h1000_0000);
    wr(12'h408, 32'hEFFF_FFFF);
    chk("R8", "rx_offset clear", {30'b0, rx_offset}, 32'h0);
    rd_chk("R8", 12'h408, 32'h0);
  endtask

  task automatic t_dma;
    wr(12'h448, 32'h00C0_0000);
    chk("R9", "first go", {31'b0, tx_go}, 32'h1);
    chk("R9", "first queue", {31'b0, tx_go_q}, 32'h1);
    @(negedge clk);
    chk("R9", "second go", {31'b0, tx_go}, 32'h1);
    chk("R9", "second queue", {31'b0, tx_go_q}, 32'h0);
    @(negedge clk);
    chk("R9", "go ends", {31'b0, tx_go}, 32'h0);
    wr(12'h448, 32'h0040_0000);
    chk("R9", "low-only queue", {30'b0, tx_go, tx_go_q}, 32'h2);
    @(negedge clk);
    chk("R9", "low-only single", {31'b0, tx_go}, 32'h0);
    rd_chk("R9", 12'h448, 32'h0);
  endtask

  task automatic t_ptrs;
    for (int i = 0; i < 4; i++) wr(12'h480 + 12'(4 * i), 32'h1000_0000 + 32'(i));
    for (int i = 0; i < 4; i++) wr(12'h4A0 + 12'(4 * i), 32'h2000_0000 + 32'(i));
    for (int i = 0; i < 2; i++) wr(12'h4E0 + 12'(4 * i), 32'h3000_0000 + 32'(i));
    for (int i = 0; i < 4; i++) rd_chk("R10", 12'h480 + 12'(4 * i), 32'h1000_0000 + 32'(i));
    for (int i = 0; i < 4; i++) rd_chk("R10", 12'h4A0 + 12'(4 * i), 32'h2000_0000 + 32'(i));
    for (int i = 0; i < 2; i++) rd_chk("R10", 12'h4E0 + 12'(4 * i), 32'h3000_0000 + 32'(i));
  endtask

  task automatic t_rxload;
    wr(12'h4A8, 32'hCAFE_0040);
    chk("R11", "load valid", {31'b0, rx_ld_valid}, 32'h1);
    chk("R11", "load queue", {30'b0, rx_ld_q}, 32'h2);
    chk("R11", "load ptr", rx_ld_ptr, 32'hCAFE_0040);
    @(negedge clk);
    chk("R11", "load single", {31'b0, rx_ld_valid}, 32'h0);
    wr(12'h484, 32'h1234_5678);
    chk("R11", "first-rx no load", {31'b0, rx_ld_valid}, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(12'h458, 32'h0000_00F0);
    wr(12'h454, 32'hFFFF_FFFF);
    rd_chk("R12", 12'h454, 32'h0);
    rd_chk("R12", 12'h458, 32'h0000_00F0);
    wr(12'h4A5, 32'hDEAD_BEEF);
    chk("R12", "unaligned no load", {31'b0, rx_ld_valid}, 32'h0);
    rd_chk("R12", 12'h4A4, 32'h2000_0001);
    wr(12'h4B0, 32'hDEAD_BEEF);
    rd_chk("R12", 12'h4B0, 32'h0);
    rd_chk("R12", 12'hFFC, 32'h0);
    wr(12'h458, 32'h0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events_and_clear();
    t_mask_irq();
    t_mgmt();
    t_port();
    t_dma();
    t_ptrs();
    t_rxload();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule